// File: doc/BRIEF.md
# Sequential Stream-Buffer Prefetching Cache

This block is a small direct-mapped lookup cache that keeps only tags. It is paired with a two-entry stream buffer that runs ahead of demand references and fetches the blocks that follow the current one in address order. A core presents a byte address with `reqValid` and holds it until `reqReady` is high. In that accept cycle the block reports whether the reference hit, and whether the hit was supplied by the stream buffer rather than the cache.

The memory side issues one block read at a time: a one-cycle request strobe carrying a block number, and later a one-cycle response strobe. A demand reference that misses in the cache but matches the head of the stream buffer counts as a hit. That block moves into the cache and the freed buffer slot is refilled with the next sequential block.

A reference that misses in both the cache and the buffer throws away the buffered blocks, fetches the missing block, and restarts the stream just after it. Three saturating counters separate plain cache hits, buffer hits and true misses.

Top module: `stream_prefetch_cache`

## Requirements
- R1: The byte address splits into a 5-bit offset (bits 4:0, 32-byte blocks), a log2(LINES)-bit line index above it and a tag in the remaining upper bits. Any two addresses in one block share a line. Blocks whose numbers differ by LINES evict each other.
- R2: A reference that hits in the cache is accepted in the same cycle it is presented: `reqReady`=1, `respHit`=1, `respSbHit`=0.
- R3: A reference that misses in both the cache and the stream buffer is accepted with `respHit`=0 in the cycle the demand response arrives, no sooner than the memory latency. Its block is then resident in the cache.
- R4: Bringing a block into the cache on a true miss starts prefetching the following block into the stream buffer and not into the cache. A reference to that following block is therefore reported with `respSbHit`=1.
- R5: The stream buffer holds at most two blocks in ascending block order, and only the head entry is matched. A reference to the second buffered block is a true miss.
- R6: A stream-buffer hit is accepted with `respHit`=1 and `respSbHit`=1. It writes the block into the cache, so a later reference to it is a plain hit, and it prefetches the next sequential block into the freed slot.
- R7: A true miss discards the buffer contents and restarts prefetching at the block after the missed one. A block that was buffered before the miss is a true miss afterwards.
- R8: A reference to the block whose prefetch is still outstanding while the buffer is empty is held (`reqReady`=0) until that prefetch returns. It is then accepted as a stream-buffer hit.
- R9: At most one memory request is outstanding at a time, and prefetches are issued only while a buffer entry is free. A sequential run over N blocks from an empty state issues exactly N+2 requests.
- R10: Three CNT_W-bit counters count plain cache hits, stream-buffer hits and true misses. Each counter stops at its all-ones value and never wraps. All three are zero after reset.
- R11: A stream stepping by 2 bytes from an empty state gives exactly one true miss. Every later block is a stream-buffer hit and all other references are cache hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core reference present; held until accepted |
| reqAddr | input | ADDR_W | Byte address of the reference |
| reqReady | output | 1 | Reference accepted this cycle |
| respHit | output | 1 | Accepted reference hit (cache or stream buffer) |
| respSbHit | output | 1 | Accepted reference was supplied by the stream buffer |
| memReqValid | output | 1 | One-cycle block read request |
| memReqBlk | output | ADDR_W-5 | Block number requested |
| memRespValid | input | 1 | One-cycle response to the outstanding request |
| cntHit | output | CNT_W | Saturating count of plain cache hits |
| cntSbHit | output | CNT_W | Saturating count of stream-buffer hits |
| cntMiss | output | CNT_W | Saturating count of true misses |

## Verification
Several rules are checked on every cycle by the assertions:
- the single-outstanding-request rule, and that every response answers a request;
- that a reported miss only ever completes together with a memory response;
- that a buffer hit is always also reported as a hit;
- that the counters never move backwards and step by one per accepted hit.

Whether a given reference should hit, hit in the buffer or miss depends on the history of the stream. Only the bench scenarios can show this, by comparing each accept against a reference model of the cache tags and the expected stream head. Those scenarios cover:
- the stall on an in-flight prefetch;
- the head-only match;
- the flush after a jump;
- line conflicts;
- counter saturation.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // Strobes from the controller to the datapath, valid for one cycle.
  typedef struct packed {
    logic cacheWr;      // install the current reference's block
    logic sbPop;        // retire the stream-buffer head
    logic demandIssue;  // flush buffer, fetch current block
    logic pfIssue;      // fetch next sequential block into buffer
    logic incHit;
    logic incSb;
    logic incMiss;
  } spcStrobes_t;
endpackage

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int SB_DEPTH    = 2,
  parameter int CNT_W       = 32,
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int TAG_W = BLK_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  spcStrobes_t       st,
  input  logic              memRespValid,
  output logic              cacheHit,
  output logic              headHit,
  output logic              pfMatch,
  output logic              pfWanted,
  output logic              busy,
  output logic              memReqValid,
  output logic [BLK_W-1:0]  memReqBlk,
  output logic [CNT_W-1:0]  cntHit,
  output logic [CNT_W-1:0]  cntSb,
  output logic [CNT_W-1:0]  cntMiss
);
  logic [BLK_W-1:0] reqBlk;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  assign reqBlk = reqAddr[ADDR_W-1:OFF_W];
  assign reqIdx = reqBlk[IDX_W-1:0];
  assign reqTag = reqBlk[BLK_W-1:IDX_W];

  // Tag store
  logic [LINES-1:0] lineValid;
  logic [TAG_W-1:0] tagMem [LINES];

  always_ff @(posedge clk) begin
    if (!rstN) lineValid <= '0;
    else if (st.cacheWr) lineValid[reqIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.cacheWr) tagMem[reqIdx] <= reqTag;
  end

  assign cacheHit = lineValid[reqIdx] && (tagMem[reqIdx] == reqTag);

  // Memory request tracking and stream state
  logic [BLK_W-1:0] pendBlk, nextPf;
  logic             pendPf, streamOn;
  logic [SB_DEPTH-1:0] sbV, nV;
  logic [BLK_W-1:0]    sbB [SB_DEPTH];
  logic [BLK_W-1:0]    nB  [SB_DEPTH];
  logic push;

  assign push        = memRespValid && busy && pendPf;
  assign memReqValid = st.demandIssue | st.pfIssue;
  assign memReqBlk   = st.demandIssue ? reqBlk : nextPf;
  assign headHit     = sbV[0] && (sbB[0] == reqBlk);
  assign pfWanted    = streamOn && !busy && !sbV[SB_DEPTH-1];
  assign pfMatch     = streamOn && !sbV[0] &&
                       (busy ? (pendPf && pendBlk == reqBlk) : (nextPf == reqBlk));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pendPf   <= 1'b0;
      pendBlk  <= '0;
      nextPf   <= '0;
      streamOn <= 1'b0;
    end else begin
      if (memReqValid) begin
        busy    <= 1'b1;
        pendPf  <= st.pfIssue;
        pendBlk <= memReqBlk;
      end else if (memRespValid) begin
        busy <= 1'b0;
      end
      if (st.demandIssue) begin
        nextPf   <= reqBlk + BLK_W'(1);
        streamOn <= 1'b1;
      end else if (st.pfIssue) begin
        nextPf <= nextPf + BLK_W'(1);
      end
    end
  end

  // Stream buffer: shift FIFO, head at entry 0
  always_comb begin
    logic placed;
    nV = sbV;
    nB = sbB;
    placed = 1'b0;
    if (st.demandIssue) begin
      nV = '0;
    end else begin
      if (st.sbPop) begin
        for (int i = 0; i < SB_DEPTH; i++) begin
          nV[i] = (i + 1 < SB_DEPTH) ? sbV[(i+1) % SB_DEPTH] : 1'b0;
          nB[i] = sbB[(i+1) % SB_DEPTH];
        end
      end
      if (push) begin
        for (int i = 0; i < SB_DEPTH; i++) begin
          if (!placed && !nV[i]) begin
            nV[i]  = 1'b1;
            nB[i]  = pendBlk;
            placed = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sbV <= '0;
    else       sbV <= nV;
  end

  always_ff @(posedge clk) begin
    sbB <= nB;
  end

  // Saturating event counters
  logic [2:0]            incVec;
  logic [2:0][CNT_W-1:0] cntVec;
  assign incVec = {st.incMiss, st.incSb, st.incHit};

  for (genvar g = 0; g < 3; g++) begin : gCnt
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rstN) val <= '0;
      else if (incVec[g] && (val != '1)) val <= val + CNT_W'(1);
    end
    assign cntVec[g] = val;
  end

  assign cntHit  = cntVec[0];
  assign cntSb   = cntVec[1];
  assign cntMiss = cntVec[2];
endmodule

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cacheHit,
  input  logic        headHit,
  input  logic        pfMatch,
  input  logic        pfWanted,
  input  logic        busy,
  input  logic        memRespValid,
  output spcStrobes_t st,
  output logic        reqReady,
  output logic        respHit,
  output logic        respSbHit
);
  typedef enum logic {S_IDLE, S_FILL} state_t;
  state_t state, nState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nState;
  end

  always_comb begin
    st        = '0;
    reqReady  = 1'b0;
    respHit   = 1'b0;
    respSbHit = 1'b0;
    nState    = state;
    case (state)
      S_IDLE: begin
        if (!reqValid) begin
          st.pfIssue = pfWanted;
        end else if (cacheHit) begin
          reqReady   = 1'b1;
          respHit    = 1'b1;
          st.incHit  = 1'b1;
          st.pfIssue = pfWanted;
        end else if (headHit) begin
          reqReady   = 1'b1;
          respHit    = 1'b1;
          respSbHit  = 1'b1;
          st.cacheWr = 1'b1;
          st.sbPop   = 1'b1;
          st.incSb   = 1'b1;
          st.pfIssue = pfWanted;
        end else if (pfMatch) begin
          // wait for the in-flight (or about-to-issue) head prefetch
          st.pfIssue = pfWanted;
        end else if (!busy) begin
          st.demandIssue = 1'b1;
          nState         = S_FILL;
        end
      end
      S_FILL: begin
        if (memRespValid) begin
          reqReady   = 1'b1;
          st.cacheWr = 1'b1;
          st.incMiss = 1'b1;
          nState     = S_IDLE;
        end
      end
      default: nState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/stream_prefetch_cache.sv
module stream_prefetch_cache
  import spc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int CNT_W       = 32,
  localparam int BLK_W = ADDR_W - $clog2(BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              respHit,
  output logic              respSbHit,
  output logic              memReqValid,
  output logic [BLK_W-1:0]  memReqBlk,
  input  logic              memRespValid,
  output logic [CNT_W-1:0]  cntHit,
  output logic [CNT_W-1:0]  cntSbHit,
  output logic [CNT_W-1:0]  cntMiss
);
  spcStrobes_t st;
  logic cacheHit, headHit, pfMatch, pfWanted, busy;

  spc_datapath #(
    .ADDR_W(ADDR_W), .LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES),
    .SB_DEPTH(2), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .st(st),
    .memRespValid(memRespValid), .cacheHit(cacheHit), .headHit(headHit),
    .pfMatch(pfMatch), .pfWanted(pfWanted), .busy(busy),
    .memReqValid(memReqValid), .memReqBlk(memReqBlk),
    .cntHit(cntHit), .cntSb(cntSbHit), .cntMiss(cntMiss)
  );

  spc_control uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cacheHit(cacheHit),
    .headHit(headHit), .pfMatch(pfMatch), .pfWanted(pfWanted), .busy(busy),
    .memRespValid(memRespValid), .st(st), .reqReady(reqReady),
    .respHit(respHit), .respSbHit(respSbHit)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             respHit,
  input logic             respSbHit,
  input logic             memReqValid,
  input logic             memRespValid,
  input logic [CNT_W-1:0] cntHit,
  input logic [CNT_W-1:0] cntSbHit,
  input logic [CNT_W-1:0] cntMiss
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN)             outstanding <= 1'b0;
    else if (memReqValid)  outstanding <= 1'b1;
    else if (memRespValid) outstanding <= 1'b0;
  end

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);
  p_resp_has_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    memRespValid |-> outstanding);
  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> reqValid);
  p_miss_on_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !respHit) |-> memRespValid);
  p_sb_is_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    respSbHit |-> (reqReady && respHit));
  p_no_wrap_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntHit >= $past(cntHit));
  p_no_wrap_sb_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntSbHit >= $past(cntSbHit));
  p_no_wrap_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntMiss >= $past(cntMiss));
  p_hit_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && respHit && !respSbHit && cntHit != '1) |=> cntHit == $past(cntHit) + 1'b1);
  p_sb_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (respSbHit && cntSbHit != '1) |=> cntSbHit == $past(cntSbHit) + 1'b1);
endmodule

bind stream_prefetch_cache spc_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respHit(respHit), .respSbHit(respSbHit), .memReqValid(memReqValid),
  .memRespValid(memRespValid), .cntHit(cntHit), .cntSbHit(cntSbHit),
  .cntMiss(cntMiss)
);

// File: tb/tb_stream_prefetch_cache.sv
module tb_stream_prefetch_cache;
  localparam int ADDR_W = 16;
  localparam int LINES  = 16;
  localparam int CNT_W  = 8;
  localparam int BLK_W  = ADDR_W - 5;
  localparam int LAT    = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqReady, respHit, respSbHit, memReqValid, memRespValid;
  logic [BLK_W-1:0] memReqBlk;
  logic [CNT_W-1:0] cntHit, cntSbHit, cntMiss;

  always #4 clk = ~clk;

  stream_prefetch_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respHit(respHit), .respSbHit(respSbHit),
    .memReqValid(memReqValid), .memReqBlk(memReqBlk), .memRespValid(memRespValid),
    .cntHit(cntHit), .cntSbHit(cntSbHit), .cntMiss(cntMiss)
  );

  // Fixed-latency memory
  int memCnt = 0;
  int memReqs = 0;
  int memOverlap = 0;
  assign memRespValid = (memCnt == 1);
  always @(posedge clk) begin
    if (!rstN) memCnt <= 0;
    else if (memReqValid) begin
      if (memCnt > 1) memOverlap <= memOverlap + 1;
      memCnt  <= LAT;
      memReqs <= memReqs + 1;
    end else if (memCnt != 0) memCnt <= memCnt - 1;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model
  bit mValid [LINES];
  int mTag   [LINES];
  bit mOn = 1'b0;
  int mNext = 0;
  int eHit = 0, eSb = 0, eMiss = 0;

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // 0 = cache hit, 1 = stream-buffer hit, 2 = true miss
  function automatic int modelRef(int a);
    int blk = a / 32;
    int idx = blk % LINES;
    int tg  = blk / LINES;
    if (mValid[idx] && mTag[idx] == tg) begin
      eHit = sat(eHit + 1);
      return 0;
    end
    mValid[idx] = 1'b1;
    mTag[idx]   = tg;
    if (mOn && blk == mNext) begin
      mNext = blk + 1;
      eSb = sat(eSb + 1);
      return 1;
    end
    mOn = 1'b1;
    mNext = blk + 1;
    eMiss = sat(eMiss + 1);
    return 2;
  endfunction

  int lastWait;

  task automatic doRef(input int a, output int kind);
    int w = 0;
    kind = -1;
    reqValid = 1'b1;
    reqAddr  = ADDR_W'(a);
    while (1) begin
      #1;
      if (reqReady) begin
        kind = respSbHit ? 1 : (respHit ? 0 : 2);
        @(negedge clk);
        break;
      end
      @(negedge clk);
      w++;
      if (w > 100) begin
        errors++;
        $display("FAIL R3: reference 0x%0h never accepted (actual stall %0d expected <100)", a, w);
        break;
      end
    end
    lastWait = w;
  endtask

  task automatic refChk(input int a, input string tag);
    int k, e;
    doRef(a, k);
    e = modelRef(a);
    chk(tag, k, e);
  endtask

  task automatic refChkKind(input int a);
    int k, e;
    doRef(a, k);
    e = modelRef(a);
    chk(e == 0 ? "R2 kind" : (e == 1 ? "R6 kind" : "R3 kind"), k, e);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int k;
    int cur;
    void'($urandom(32'd4242));
    for (int i = 0; i < LINES; i++) begin mValid[i] = 1'b0; mTag[i] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset cntHit", int'(cntHit), 0);
    chk("R10 reset cntSbHit", int'(cntSbHit), 0);
    chk("R10 reset cntMiss", int'(cntMiss), 0);
    chk("R2 reset reqReady", int'(reqReady), 0);
    chk("R9 reset memReqValid", int'(memReqValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11 / R4 / R6: 2-byte sequential stream over 8 blocks
    for (int a = 0; a < 256; a += 2) refChk(a, "R11 seq kind");
    reqValid = 1'b0;
    #1;
    chk("R11 misses", int'(cntMiss), 1);
    chk("R11 sb hits", int'(cntSbHit), 7);
    chk("R11 hits", int'(cntHit), 120);
    repeat (20) @(negedge clk);
    chk("R9 request count N+2", memReqs, 10);

    // R6: buffer-supplied block now lives in the cache
    doRef(3 * 32 + 6, k);
    chk("R6 installed block hits", k, int'(modelRef(3 * 32 + 6)));
    chk("R2 hit no stall", lastWait, 0);

    // R5: buffer holds 8,9; second entry is not matched
    refChk(9 * 32, "R5 second entry is miss");
    // R7: block 8 was buffered before the flush
    refChk(8 * 32, "R7 flushed block misses");
    chk("R3 miss waits latency", int'(lastWait >= LAT - 1), 1);

    // R8: stall on in-flight prefetch
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    refChk(100 * 32, "R3 jump miss");
    doRef(101 * 32, k);
    chk("R8 stalled ref is sb hit", k, int'(modelRef(101 * 32)));
    chk("R8 stall observed", int'(lastWait >= 2), 1);

    // R1: same block, other offset; conflicting line
    refChk(100 * 32 + 31, "R1 same block hit");
    refChk((100 + LINES) * 32, "R1 conflict miss");
    refChk(100 * 32 + 4, "R1 evicted miss");

    // random mix
    cur = 1024;
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom % 10);
      if (r < 6) cur = cur + 2;
      else if (r < 8) cur = int'($urandom % 64) * 32 + int'($urandom % 16) * 2;
      else cur = (cur & ~31) + 32;
      cur = cur % 4096;
      refChkKind(cur);
    end

    // long sequential run to reach saturation
    for (int a = 8192; a < 8192 + 640; a += 2) refChkKind(a);
    reqValid = 1'b0;
    #1;
    chk("R10 cntHit vs model", int'(cntHit), eHit);
    chk("R10 cntSbHit vs model", int'(cntSbHit), eSb);
    chk("R10 cntMiss vs model", int'(cntMiss), eMiss);
    chk("R10 hit counter saturated", int'(cntHit), CMAX);
    chk("R9 no overlapping requests", memOverlap, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule